// File: doc/BRIEF.md
# DRAM Bank Row-State Tracker

This block sits inside a DRAM controller and follows the row state of every bank from the command stream the controller issues. Each clock cycle it takes one decoded command, a bank number and the address-bit-10 flag. It tells the scheduler which banks may take a row open (ACTIVATE) and which may take a column access (READ or WRITE) in the current cycle. It keeps a per-bank timer for the minimum row-open time and for the precharge recovery time.

A READ or WRITE that carries the auto-precharge flag closes its row by itself. The close happens on the first cycle in which the burst has finished and the row has been open for at least the minimum time. A burst-stop command cuts short a read burst that is in flight, and the row stays open. Any command that the current state does not allow raises an error flag in the cycle it is presented and changes nothing. The scheduler is expected to consult the legality outputs so that this does not happen. Refresh, arbitration and the data path are handled elsewhere.

Top module: `dram_bank_tracker`

## Requirements
- R1: Reset rules. While reset is held, and right after it, every bank is idle. The state code is 0 for idle, 1 for row open and 2 for precharging, carried in `bank_state[2b+1:2b]`. All `act_ok` bits are 1, all `rw_ok` bits are 0 and `cmd_err` is 0.
- R2: ACTIVATE rules. ACTIVATE (code 1) to an idle bank makes that bank's state 1 after the next edge. ACTIVATE to a bank that is open or precharging is an error. `act_ok[b]` is 1 exactly when bank b is idle.
- R3: Column access rules. READ (code 2) and WRITE (code 3) are legal only when all three of these hold: the addressed bank is open, that bank has no auto precharge pending, and no burst from the last column command is still running. A burst occupies BURST_LEN cycles, so the next column command to any bank is legal BURST_LEN cycles after the previous one. `rw_ok[b]` reports this legality for bank b.
- R4: Precharge timing. A bank that starts a precharge shows state 2, and it returns to state 0 so that ACTIVATE is legal exactly T_RP cycles after the precharge was registered, and not earlier.
- R5: Single-bank precharge. PRECHARGE (code 4) with the flag low closes only the addressed bank. It is an error if that open bank is fewer than T_RAS cycles past its ACTIVATE, has a burst running, or has auto precharge pending.
- R6: All-bank precharge. PRECHARGE with the flag high closes every open bank and ignores the bank number. It is an error, with no bank changed, if any open bank fails the R5 conditions.
- R7: Precharge on a closed bank. A single-bank PRECHARGE to an idle or precharging bank raises no error and has no effect. In particular it does not restart that bank's recovery timer.
- R8: Auto-precharge flag scope. The flag on a READ or WRITE requests auto precharge for that command alone. A later column command without the flag leaves the row open.
- R9: Auto-precharge timing. With auto precharge requested, the bank enters state 2 at the first edge at or after both of these points: BURST_LEN cycles after the column command, and T_RAS cycles after the bank's ACTIVATE.
- R10: Burst stop. BURST TERMINATE (code 5) ends a running read burst that has no auto precharge, and it ignores the bank number. The row stays open, and a column command is legal in the next cycle. Burst stop with no such read running is an error.
- R11: Error behaviour. An illegal command raises `cmd_err` in the same cycle it is presented and changes no bank state. Codes 0, 6 and 7 are no-operations.
- R12: Concurrent access. While one bank waits on its auto precharge after its burst has ended, a READ or WRITE to another open bank is legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop |
| cmd_bank | input | BANK_W | Addressed bank |
| cmd_a10 | input | 1 | All-bank select on precharge, auto-precharge request on read/write |
| act_ok | output | NUM_BANKS | Bank may take ACTIVATE this cycle |
| rw_ok | output | NUM_BANKS | Bank may take READ or WRITE this cycle |
| bank_state | output | 2*NUM_BANKS | Per-bank state code, two bits per bank |
| cmd_err | output | 1 | Presented command is illegal and was dropped |

## Verification
The assertions assume four things about the inputs. The command code and bank number are stable and valid around each rising edge. The bank count is a power of two, so every bank number addresses a real bank. T_RP is at least 2. Counter widths follow from the parameters. The stimulus is driven only on the falling edge from one sequencing process. It deliberately includes illegal commands: early activates, early precharges, column commands during a burst and stray burst stops. These check that the error path leaves the state untouched, rather than steering around it.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_PRECH = 2'd2
  } bank_st_e;

  // status a bank publishes to the command checker
  typedef struct packed {
    bank_st_e st;
    logic     ras_done;
    logic     ap_pend;
    logic     busy;
    logic     busy_rd;
  } bank_stat_t;

  // accepted operation steered to one bank
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic bst;
    logic ap;
  } bank_op_t;

  // auto precharge may begin once the burst is over and the row is old enough
  function automatic logic ap_due(input logic pend, input logic burst_over,
                                  input logic ras_over);
    return pend && burst_over && ras_over;
  endfunction

endpackage

// File: rtl/dram_bank_fsm.sv
module dram_bank_fsm
  import dram_bank_pkg::*;
#(
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  bank_op_t   op,
  output bank_stat_t stat,
  output logic       ap_fire
);

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t RAS_LOAD = cnt_t'(T_RAS - 1);
  localparam cnt_t RP_LOAD  = cnt_t'(T_RP - 1);
  localparam cnt_t BL_LOAD  = cnt_t'(BURST_LEN - 1);

  function automatic cnt_t tick(input cnt_t v);
    return (v == '0) ? v : v - cnt_t'(1);
  endfunction

  bank_st_e st_q;
  cnt_t     ras_q, rp_q, burst_q;
  logic     ap_q, rd_q;

  always_comb begin
    ap_fire       = (st_q == BK_OPEN) && ap_due(ap_q, burst_q == '0, ras_q == '0);
    stat.st       = st_q;
    stat.ras_done = (ras_q == '0);
    stat.ap_pend  = ap_q;
    stat.busy     = (burst_q != '0);
    stat.busy_rd  = rd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= BK_IDLE;
      ras_q   <= '0;
      rp_q    <= '0;
      burst_q <= '0;
      ap_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      ras_q   <= tick(ras_q);
      rp_q    <= tick(rp_q);
      burst_q <= tick(burst_q);
      unique case (st_q)
        BK_IDLE: if (op.act) begin
          st_q  <= BK_OPEN;
          ras_q <= RAS_LOAD;
        end
        BK_OPEN: begin
          if (op.pre || ap_fire) begin
            st_q <= BK_PRECH;
            rp_q <= RP_LOAD;
            ap_q <= 1'b0;
          end else if (op.rd || op.wr) begin
            burst_q <= BL_LOAD;
            rd_q    <= op.rd;
            ap_q    <= op.ap;
          end else if (op.bst) begin
            burst_q <= '0;
          end
        end
        BK_PRECH: if (rp_q <= cnt_t'(1)) st_q <= BK_IDLE;
        default: st_q <= BK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_cmd_check.sv
module dram_cmd_check
  import dram_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [2:0]                   cmd,
  input  logic [BANK_W-1:0]            cmd_bank,
  input  logic                         cmd_a10,
  input  bank_stat_t [NUM_BANKS-1:0]   stat,
  output bank_op_t   [NUM_BANKS-1:0]   op,
  output logic                         cmd_err
);

  bank_stat_t           sel;
  logic                 any_busy, pre_block;
  logic [NUM_BANKS-1:0] bst_hit;

  always_comb begin
    any_busy  = 1'b0;
    pre_block = 1'b0;
    bst_hit   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      any_busy   |= stat[b].busy;
      pre_block  |= (stat[b].st == BK_OPEN) &&
                    (!stat[b].ras_done || stat[b].ap_pend || stat[b].busy);
      bst_hit[b]  = stat[b].busy && stat[b].busy_rd && !stat[b].ap_pend;
    end
    sel = stat[cmd_bank];

    cmd_err = 1'b0;
    op      = '0;
    case (cmd)
      CMD_ACT: begin
        if (sel.st != BK_IDLE) cmd_err = 1'b1;
        else op[cmd_bank].act = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        if (sel.st != BK_OPEN || sel.ap_pend || any_busy) cmd_err = 1'b1;
        else begin
          op[cmd_bank].rd = (cmd == CMD_RD);
          op[cmd_bank].wr = (cmd == CMD_WR);
          op[cmd_bank].ap = cmd_a10;
        end
      end
      CMD_PRE: begin
        if (cmd_a10) begin
          if (pre_block) cmd_err = 1'b1;
          else for (int b = 0; b < NUM_BANKS; b++) op[b].pre = (stat[b].st == BK_OPEN);
        end else if (sel.st == BK_OPEN) begin
          if (!sel.ras_done || sel.ap_pend || sel.busy) cmd_err = 1'b1;
          else op[cmd_bank].pre = 1'b1;
        end
      end
      CMD_BST: begin
        if (bst_hit == '0) cmd_err = 1'b1;
        else for (int b = 0; b < NUM_BANKS; b++) op[b].bst = bst_hit[b];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dram_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int T_MAX1   = (T_RAS > T_RP) ? T_RAS : T_RP,
  localparam int T_MAX    = (T_MAX1 > BURST_LEN) ? T_MAX1 : BURST_LEN,
  localparam int CNT_W    = $clog2(T_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             cmd,
  input  logic [BANK_W-1:0]      cmd_bank,
  input  logic                   cmd_a10,
  output logic [NUM_BANKS-1:0]   act_ok,
  output logic [NUM_BANKS-1:0]   rw_ok,
  output logic [2*NUM_BANKS-1:0] bank_state,
  output logic                   cmd_err
);

  bank_stat_t [NUM_BANKS-1:0] stat;
  bank_op_t   [NUM_BANKS-1:0] op;
  logic       [NUM_BANKS-1:0] bank_ap_fire;
  logic                       bus_busy;

  dram_cmd_check #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_check (
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_a10(cmd_a10),
    .stat(stat), .op(op), .cmd_err(cmd_err)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    dram_bank_fsm #(
      .T_RAS(T_RAS), .T_RP(T_RP), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .op(op[g]),
      .stat(stat[g]), .ap_fire(bank_ap_fire[g])
    );
  end

  always_comb begin
    bus_busy = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) bus_busy |= stat[b].busy;
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_state[2*b +: 2] = stat[b].st;
      act_ok[b] = (stat[b].st == BK_IDLE);
      rw_ok[b]  = (stat[b].st == BK_OPEN) && !stat[b].ap_pend && !bus_busy;
    end
  end

endmodule

// File: rtl/dram_bank_tracker_chk.sv
module dram_bank_tracker_chk
  import dram_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             cmd,
  input logic [BANK_W-1:0]      cmd_bank,
  input logic                   cmd_a10,
  input logic [NUM_BANKS-1:0]   act_ok,
  input logic [NUM_BANKS-1:0]   rw_ok,
  input logic [2*NUM_BANKS-1:0] bank_state,
  input logic                   cmd_err,
  input logic [NUM_BANKS-1:0]   bank_ap_fire
);

  logic              act_q;
  logic [BANK_W-1:0] bank_q;
  logic [1:0]        sel_st;

  assign sel_st = bank_state[{cmd_bank, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    act_q  <= rst_n && (cmd == CMD_ACT) && !cmd_err;
    bank_q <= cmd_bank;
  end

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> bank_state[{bank_q, 1'b0} +: 2] == 2'd1);

  // R11
  rw_closed_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_RD || cmd == CMD_WR) && sel_st != 2'd1) |-> cmd_err);

  // R7
  pre_closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && !cmd_a10 && sel_st != 2'd1) |-> !cmd_err);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    // R9
    ap_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_ap_fire[g] |=> bank_state[2*g +: 2] == 2'd2);
    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state[2*g +: 2] == 2'd0 &&
       !(cmd == CMD_ACT && cmd_bank == BANK_W'(g) && !cmd_err))
      |=> bank_state[2*g +: 2] == 2'd0);
    // R3
    ok_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_ok[g] && rw_ok[g]));
  end

endmodule

bind dram_bank_tracker dram_bank_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_a10(cmd_a10),
  .act_ok(act_ok), .rw_ok(rw_ok), .bank_state(bank_state), .cmd_err(cmd_err),
  .bank_ap_fire(bank_ap_fire)
);

// File: tb/dram_bank_tracker_tb.sv
`timescale 1ns/1ps
module dram_bank_tracker_tb;

  localparam int NB = 4, TRAS = 6, TRP = 3, BL = 4;

  logic clk = 1'b0, rst_n = 1'b0, cmd_a10 = 1'b0, cmd_err;
  logic [2:0] cmd = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic [NB-1:0] act_ok, rw_ok;
  logic [2*NB-1:0] bank_state;

  int checks = 0, errors = 0, cyc = 0;
  // reference model: absolute cycle stamps
  bit open_b[NB], aprq[NB], isrd[NB];
  int act_t[NB], pre_t[NB], bend[NB];
  int bus_free = -100, bus_bank = 0;

  always #5 clk = ~clk;

  dram_bank_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_a10(cmd_a10),
    .act_ok(act_ok), .rw_ok(rw_ok), .bank_state(bank_state), .cmd_err(cmd_err)
  );

  function automatic int m_state(int b);
    if (open_b[b]) return 1;
    return (cyc < pre_t[b] + TRP) ? 2 : 0;
  endfunction

  function automatic bit blocked(int b);
    return cyc < act_t[b] + TRAS || aprq[b] || cyc < bend[b];
  endfunction

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic [2:0] c, input int b, input bit a, input string tag);
    bit err, busy;
    int e_act, e_rw, e_st;
    @(negedge clk);
    cmd = c; cmd_bank = b[1:0]; cmd_a10 = a;
    #1;
    busy = cyc < bus_free;
    e_act = 0; e_rw = 0; e_st = 0;
    for (int k = 0; k < NB; k++) begin
      e_st  |= m_state(k) << (2*k);
      e_act |= int'(m_state(k) == 0) << k;
      e_rw  |= int'(m_state(k) == 1 && !aprq[k] && !busy) << k;
    end
    err = 0;
    case (c)
      3'd1: err = m_state(b) != 0;
      3'd2, 3'd3: err = m_state(b) != 1 || aprq[b] || busy;
      3'd4: if (a) begin
              for (int k = 0; k < NB; k++) if (open_b[k] && blocked(k)) err = 1;
            end else err = open_b[b] && blocked(b);
      3'd5: err = !(busy && isrd[bus_bank] && !aprq[bus_bank]);
      default: err = 0;
    endcase
    chk(int'(bank_state), e_st, tag, "bank_state");
    chk(int'(act_ok), e_act, tag, "act_ok");
    chk(int'(rw_ok), e_rw, tag, "rw_ok");
    chk(int'(cmd_err), int'(err), tag, "cmd_err");
    // edge effects: auto precharge first, then the accepted command
    for (int k = 0; k < NB; k++)
      if (open_b[k] && aprq[k] && cyc >= bend[k] && cyc >= act_t[k] + TRAS) begin
        open_b[k] = 0; aprq[k] = 0; pre_t[k] = cyc;
      end
    if (!err) case (c)
      3'd1: begin open_b[b] = 1; act_t[b] = cyc; end
      3'd2, 3'd3: begin
        bend[b] = cyc + BL; bus_free = cyc + BL; bus_bank = b;
        aprq[b] = a; isrd[b] = (c == 3'd2);
      end
      3'd4: for (int k = 0; k < NB; k++)
              if (open_b[k] && (a || k == b)) begin open_b[k] = 0; pre_t[k] = cyc; end
      3'd5: begin bus_free = cyc; bend[bus_bank] = cyc; end
      default: ;
    endcase
    cyc++;
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) step(3'd0, 0, 0, tag);
  endtask

  initial begin
    for (int k = 0; k < NB; k++) begin
      act_t[k] = -100; pre_t[k] = -100; bend[k] = -100;
    end
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(int'(bank_state), 0, "R1", "bank_state");
    chk(int'(act_ok), 15, "R1", "act_ok");
    chk(int'(rw_ok), 0, "R1", "rw_ok");
    rst_n = 1'b1;
    nops(2, "R1");
    step(3'd1, 0, 0, "R2");          // open bank 0
    step(3'd1, 0, 0, "R2");          // second activate: error
    step(3'd2, 1, 0, "R3");          // read to idle bank: error
    step(3'd2, 0, 0, "R3");
    step(3'd3, 0, 0, "R3");          // burst running: error
    nops(2, "R3");
    step(3'd3, 0, 0, "R3");          // exactly BL later: legal
    step(3'd4, 0, 0, "R5");          // burst running: error
    step(3'd7, 0, 0, "R11");         // unused code is a no-op
    nops(4, "R5");
    step(3'd4, 0, 0, "R5");
    step(3'd4, 0, 0, "R7");          // already precharging: no effect
    step(3'd1, 0, 0, "R4");          // one cycle short of T_RP: error
    step(3'd1, 0, 0, "R4");          // T_RP reached: legal
    step(3'd1, 1, 0, "R6");
    step(3'd1, 2, 0, "R6");
    step(3'd4, 3, 1, "R6");          // rows too young: error
    nops(5, "R6");
    step(3'd4, 3, 1, "R6");          // closes banks 0..2, bank bits ignored
    nops(3, "R4");
    step(3'd1, 3, 0, "R9");
    step(3'd1, 0, 0, "R9");
    step(3'd2, 3, 1, "R8");          // read with auto precharge
    step(3'd2, 3, 0, "R8");          // pending and busy: error
    nops(2, "R9");
    step(3'd2, 0, 0, "R12");         // other bank while bank 3 closes
    nops(8, "R8");                   // bank 0 must stay open
    step(3'd1, 1, 0, "R9");
    step(3'd3, 1, 1, "R9");          // T_RAS dominates the close point
    nops(9, "R9");
    step(3'd1, 2, 0, "R9");
    nops(8, "R9");
    step(3'd2, 2, 1, "R9");          // burst end dominates
    nops(6, "R9");
    step(3'd2, 0, 0, "R10");
    step(3'd5, 2, 0, "R10");         // truncate, bank bits ignored
    step(3'd3, 0, 0, "R10");         // legal next cycle
    step(3'd5, 0, 0, "R10");         // write burst: error
    nops(4, "R10");
    step(3'd5, 0, 0, "R10");         // nothing running: error
    step(3'd2, 0, 1, "R10");
    step(3'd5, 0, 0, "R10");         // read with auto precharge: error
    nops(10, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule